// File: doc/BRIEF.md
# Prioritized Address-Window Select Decoder

This block sits on the external bus path. It compares each transfer address against eight programmable address windows and drives one active-low select line for the window that claims the address. It then ends the bus cycle by itself after a per-window number of wait states. Each window holds a base address, a don't-care mask, a valid flag, a data-port width and a wait count. Software fills these in through a single-cycle write port. When windows overlap, the window with the lowest index wins.

A transfer begins with a one-cycle start strobe, which carries the address and the operand size. The block captures the winning window's settings at that edge. It holds the select and the port width, and passes the operand size through, for the whole cycle. It then pulses an acknowledge. An address that no window claims gets no select, and an error pulse replaces the acknowledge. A start strobe that arrives while a cycle is in progress is dropped.

Top module: `csd_top`

## Requirements
- R1: Window k matches when it is valid and, for every address bit whose mask bit is 0, the address bit equals the base bit. Mask bits set to 1 are don't-care.
- R2: When more than one window matches, the lowest-numbered window is selected.
- R3: A window whose valid flag is clear never matches. Reset clears the valid flag of every window.
- R4: The select for the winning window (`cs_n[k]` low, all others high) is low from the first cycle after the start edge through the cycle that carries the termination pulse. All selects are high in the cycle after that.
- R5: With a wait count of N (0..15), `xfer_ack` is high in the cycle N clocks after the first cycle of the transfer. N=0 therefore acknowledges in the first cycle after the start edge.
- R6: `xfer_ack` and `unmapped_err` are single-cycle pulses.
- R7: During a cycle, `port_width` shows the winning window's width: 00 = 32-bit, 01 = 8-bit, 10 = 16-bit. It reads 00 when idle.
- R8: During a cycle, `op_size` repeats the operand size captured at the start edge: 00 = byte, 01 = word, 10 = longword. It reads 00 when idle.
- R9: If no window matches, no select goes low. `unmapped_err` pulses in the first cycle after the start edge, and `xfer_ack` stays low.
- R10: A start strobe sampled while a cycle is in progress, including the termination cycle, has no effect.
- R11: After reset, all selects are high and `xfer_ack` and `unmapped_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for one window's settings |
| cfg_idx | input | 3 | Index of the window to write |
| cfg_valid | input | 1 | Valid flag to write |
| cfg_base | input | 23 | Base address to write |
| cfg_mask | input | 23 | Don't-care mask to write (1 = ignore bit) |
| cfg_width | input | 2 | Port width code to write |
| cfg_wait | input | 4 | Wait count to write |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_addr | input | 23 | Transfer address |
| xfer_size | input | 2 | Operand size of the transfer |
| cs_n | output | 8 | Active-low selects, one per window |
| port_width | output | 2 | Port width of the current window |
| op_size | output | 2 | Operand size of the current transfer |
| xfer_ack | output | 1 | Internal termination pulse |
| unmapped_err | output | 1 | Pulse for a transfer that no window claims |

## Verification
The bench targets the following cases, and each would expose a specific bug:
- Addresses inside overlapping windows: a reversed priority would select window 2 where window 0 or 1 is expected.
- The first and last address of a masked range: a mask applied with inverted sense would miss one end.
- A window that is programmed but left invalid, and every window again after a second reset: a design that ignores the valid flag would select where an error is expected.
- Wait counts of 0 and 15: an off-by-one counter would acknowledge one cycle early or late.
- Start strobes during a long cycle and in its termination cycle: a design that honours them would restart or extend the cycle, which shows up as a second select or a changed latency.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int NUM_WIN = 8;
    localparam int ADDR_W  = 23;
    localparam int WAIT_W  = 4;
    localparam int IDX_W   = $clog2(NUM_WIN);

    typedef enum logic [1:0] {
        PW_32   = 2'b00,
        PW_8    = 2'b01,
        PW_16   = 2'b10,
        PW_RSVD = 2'b11
    } port_w_e;

    typedef enum logic [1:0] {
        OP_BYTE = 2'b00,
        OP_WORD = 2'b01,
        OP_LONG = 2'b10,
        OP_RSVD = 2'b11
    } op_size_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        port_w_e           width;
        logic [WAIT_W-1:0] waits;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        port_w_e           width;
        logic [WAIT_W-1:0] waits;
    } decode_t;

    function automatic logic win_hit(input win_cfg_t w, input logic [ADDR_W-1:0] a);
        return w.valid && (((a ^ w.base) & ~w.mask) == '0);
    endfunction
endpackage

// File: rtl/csd_window_regs.sv
module csd_window_regs
    import csd_pkg::*;
#(
    parameter int N_WIN = NUM_WIN,
    localparam int IW   = $clog2(N_WIN)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  logic [IW-1:0] idx,
    input  win_cfg_t wcfg,
    output win_cfg_t cfg [N_WIN]
);
    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (we && idx == IW'(i)) begin
                cfg[i] <= wcfg;
            end
        end
    end
endmodule

// File: rtl/csd_prio_match.sv
module csd_prio_match
    import csd_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  win_cfg_t          cfg [N_WIN],
    output decode_t           dec
);
    logic [N_WIN-1:0] hits;
    logic [N_WIN-1:0] below;

    for (genvar i = 0; i < N_WIN; i++) begin : g_cmp
        assign hits[i] = win_hit(cfg[i], addr);
    end

    always_comb begin
        dec = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                dec.hit   = 1'b1;
                dec.idx   = IDX_W'(i);
                dec.width = cfg[i].width;
                dec.waits = cfg[i].waits;
            end
        end
    end

    assign below = (N_WIN'(1) << dec.idx) - N_WIN'(1);

    // R2: no lower-numbered window also claims the address
    p_prio_lowest_r2: assert property (@(posedge clk) disable iff (rst)
        dec.hit |-> ((hits & below) == '0));
    // R3: a chosen window is always a valid one
    p_win_valid_r3: assert property (@(posedge clk) disable iff (rst)
        dec.hit |-> cfg[dec.idx].valid);
endmodule

// File: rtl/csd_cycle_ctrl.sv
module csd_cycle_ctrl
    import csd_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  decode_t          dec,
    input  logic [1:0]       size_in,
    output logic [N_WIN-1:0] cs_n,
    output logic [1:0]       width_o,
    output logic [1:0]       size_o,
    output logic             ack,
    output logic             err
);
    logic              busy;
    decode_t           cur;
    logic [WAIT_W-1:0] cnt;
    logic [1:0]        size_q;
    logic              term;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cur    <= '0;
            cnt    <= '0;
            size_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                cur    <= dec;
                cnt    <= dec.hit ? dec.waits : '0;
                size_q <= size_in;
            end
        end else if (cnt == '0) begin
            busy   <= 1'b0;
            cur    <= '0;
            size_q <= '0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign term    = busy && (cnt == '0);
    assign ack     = term && cur.hit;
    assign err     = term && !cur.hit;
    assign width_o = busy ? cur.width : PW_32;
    assign size_o  = busy ? size_q : 2'b00;

    for (genvar i = 0; i < N_WIN; i++) begin : g_sel
        assign cs_n[i] = !(busy && cur.hit && cur.idx == IDX_W'(i));
    end

    // R4: at most one select low at a time
    p_one_select_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    // R4: selects all released after termination
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (ack || err) |=> (&cs_n));
    // R6: acknowledge is a single pulse
    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R9: an error carries no select and no acknowledge
    p_err_no_sel_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> ((&cs_n) && !ack));
    // R10: selects hold steady through a running cycle
    p_hold_sel_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !term) |=> $stable(cs_n));
endmodule

// File: rtl/csd_top.sv
module csd_top
    import csd_pkg::*;
#(
    parameter int N_WIN = NUM_WIN,
    localparam int IW   = $clog2(N_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic              cfg_valid,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [1:0]        cfg_width,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              xfer_start,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [1:0]        xfer_size,
    output logic [N_WIN-1:0]  cs_n,
    output logic [1:0]        port_width,
    output logic [1:0]        op_size,
    output logic              xfer_ack,
    output logic              unmapped_err
);
    win_cfg_t wcfg;
    win_cfg_t cfg [N_WIN];
    decode_t  dec;

    always_comb begin
        wcfg.valid = cfg_valid;
        wcfg.base  = cfg_base;
        wcfg.mask  = cfg_mask;
        wcfg.width = port_w_e'(cfg_width);
        wcfg.waits = cfg_wait;
    end

    csd_window_regs #(.N_WIN(N_WIN)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wcfg(wcfg), .cfg(cfg)
    );

    csd_prio_match #(.N_WIN(N_WIN)) u_match (
        .clk(clk), .rst(rst), .addr(xfer_addr), .cfg(cfg), .dec(dec)
    );

    csd_cycle_ctrl #(.N_WIN(N_WIN)) u_ctrl (
        .clk(clk), .rst(rst), .start(xfer_start), .dec(dec), .size_in(xfer_size),
        .cs_n(cs_n), .width_o(port_width), .size_o(op_size),
        .ack(xfer_ack), .err(unmapped_err)
    );

    // R11: outputs quiet in the cycle after reset
    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(rst) |-> ((&cs_n) && !xfer_ack && !unmapped_err));
endmodule

// File: tb/test_csd_top.sv
module test_csd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_valid = 1'b0;
    logic [22:0] cfg_base = '0;
    logic [22:0] cfg_mask = '0;
    logic [1:0]  cfg_width = '0;
    logic [3:0]  cfg_wait = '0;
    logic        xfer_start = 1'b0;
    logic [22:0] xfer_addr = '0;
    logic [1:0]  xfer_size = '0;
    logic [7:0]  cs_n;
    logic [1:0]  port_width;
    logic [1:0]  op_size;
    logic        xfer_ack;
    logic        unmapped_err;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    csd_top i_csd_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
        .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_size(xfer_size),
        .cs_n(cs_n), .port_width(port_width), .op_size(op_size),
        .xfer_ack(xfer_ack), .unmapped_err(unmapped_err)
    );

    // {addr[22:0], size[1:0], exp_idx[3:0] (8 = none), exp_width[1:0], exp_wait[3:0]}
    localparam int NV = 10;
    localparam logic [34:0] VEC [NV] = '{
        {23'h001234, 2'b10, 4'd0, 2'b00, 4'd2},
        {23'h00FFFF, 2'b00, 4'd0, 2'b00, 4'd2},
        {23'h01ABCD, 2'b01, 4'd1, 2'b10, 4'd0},
        {23'h050000, 2'b00, 4'd2, 2'b01, 4'd5},
        {23'h0FFFFF, 2'b01, 4'd2, 2'b01, 4'd5},
        {23'h200FFF, 2'b10, 4'd3, 2'b01, 4'd15},
        {23'h201000, 2'b00, 4'd8, 2'b00, 4'd0},
        {23'h3000AA, 2'b01, 4'd8, 2'b00, 4'd0},
        {23'h400000, 2'b10, 4'd7, 2'b00, 4'd3},
        {23'h7FFFFF, 2'b00, 4'd7, 2'b00, 4'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prog(input int idx, input bit v, input logic [22:0] b,
                        input logic [22:0] m, input logic [1:0] w, input logic [3:0] ws);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v;
        cfg_base = b; cfg_mask = m; cfg_width = w; cfg_wait = ws;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // inject: pulse start during the cycle and in its termination cycle (R10)
    task automatic run_xfer(input logic [22:0] a, input logic [1:0] sz, input int eidx,
                            input logic [1:0] ew, input int ewait, input bit inject);
        logic [7:0] ecs;
        int lat;
        bit seen_ack;
        bit seen_err;
        bit sel_ok;
        logic [7:0] bad_cs;
        ecs = (eidx < 8) ? ~(8'b1 << eidx) : 8'hFF;
        @(negedge clk);
        xfer_addr = a; xfer_size = sz; xfer_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
        chk(port_width == ew, "R7 width", port_width, ew);
        chk(op_size == sz, "R8 opsize", op_size, sz);
        lat = 0; sel_ok = 1'b1; bad_cs = ecs; seen_ack = 1'b0; seen_err = 1'b0;
        while (lat < 40) begin
            if (cs_n != ecs) begin sel_ok = 1'b0; bad_cs = cs_n; end
            if (xfer_ack || unmapped_err) begin
                seen_ack = xfer_ack; seen_err = unmapped_err;
                break;
            end
            if (inject && lat == 3) begin xfer_start = 1'b1; xfer_addr = 23'h001234; end
            @(posedge clk);
            @(negedge clk);
            xfer_start = 1'b0;
            lat++;
        end
        chk(sel_ok, "R1 R2 R4 select", bad_cs, ecs);
        if (eidx < 8) begin
            chk(seen_ack && !seen_err, "R5 ack kind", {seen_ack, seen_err}, 2'b10);
            chk(lat == ewait, "R5 latency", lat, ewait);
        end else begin
            chk(seen_err && !seen_ack, "R9 err kind", {seen_ack, seen_err}, 2'b01);
            chk(lat == 0, "R9 err latency", lat, 0);
        end
        if (inject) begin xfer_start = 1'b1; xfer_addr = 23'h001234; end
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
        chk(cs_n == 8'hFF && !xfer_ack && !unmapped_err, "R4 R6 release",
            {cs_n, xfer_ack, unmapped_err}, {8'hFF, 2'b00});
        if (inject) begin
            @(posedge clk);
            @(negedge clk);
            chk(cs_n == 8'hFF && op_size == 2'b00, "R10 term-cycle start ignored",
                cs_n, 8'hFF);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(cs_n == 8'hFF && !xfer_ack && !unmapped_err && port_width == 2'b00,
            "R11 reset", {cs_n, xfer_ack, unmapped_err}, {8'hFF, 2'b00});
        // R3: nothing mapped yet
        run_xfer(23'h001234, 2'b00, 8, 2'b00, 0, 1'b0);

        prog(0, 1'b1, 23'h000000, 23'h00FFFF, 2'b00, 4'd2);
        prog(1, 1'b1, 23'h010000, 23'h00FFFF, 2'b10, 4'd0);
        prog(2, 1'b1, 23'h000000, 23'h0FFFFF, 2'b01, 4'd5);
        prog(3, 1'b1, 23'h200000, 23'h000FFF, 2'b01, 4'd15);
        prog(4, 1'b0, 23'h300000, 23'h0FFFFF, 2'b10, 4'd1);
        prog(7, 1'b1, 23'h400000, 23'h3FFFFF, 2'b00, 4'd3);

        // R1 R2 R3 R5 R7 R8 R9 vector walk
        for (int v = 0; v < NV; v++) begin
            run_xfer(VEC[v][34:12], VEC[v][11:10], int'(VEC[v][9:6]),
                     VEC[v][5:4], int'(VEC[v][3:0]), 1'b0);
        end

        // R10: starts during a 15-wait cycle and in its termination cycle
        run_xfer(23'h200010, 2'b01, 3, 2'b01, 15, 1'b1);

        // R3: second reset invalidates every window
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(cs_n == 8'hFF && !xfer_ack && !unmapped_err, "R11 reset again",
            {cs_n, xfer_ack, unmapped_err}, {8'hFF, 2'b00});
        run_xfer(23'h001234, 2'b10, 8, 2'b00, 0, 1'b0);
        run_xfer(23'h400000, 2'b10, 8, 2'b00, 0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule